// File: doc/BRIEF.md
# Dual-Bank Configuration Register File

This block keeps two full copies of a search engine's configuration: a foreground bank and a background bank. Exactly one bank is active at any time. Each bank holds a control word, a segment-control register, an address register, a mask register and two persistent selectors, one for a data source and one for a destination. A one-cycle select command moves the device between the banks, so a device can leave a housekeeping context and return to its main context without reloading any register.

Register writes and reads reach only the active bank. The active control word is split into named fields and driven to the rest of the device, together with the active bank's other registers. A control write with bit 15 high stores the word and asks for a compare. A control write with bit 15 low is a device reset. That reset clears both banks to their defaults and makes the foreground bank active.

The bank selection is a two-state machine. The states are `BANK_FG` (foreground active, the reset state) and `BANK_BG` (background active). There are three transitions:

- **fg_to_bg**: a lone select-background command.
- **bg_to_fg**: a lone select-foreground command.
- **any_to_fg**: a control-reset write. It takes priority over any select command in the same cycle.

Top module: `cfg_bank_file`

## Requirements
- R1: After `rst_n` is released, the foreground bank is active and every register of both banks reads zero. A zero control word means: match flag enabled (00), full flag enabled (00), translation off (00), full-width compare partition (000), no mask (00), address increment (00) and Standard mode (00). `cmp_req` and `dev_rst` are low.
- R2: A lone `sel_bg` pulse makes the background bank active from the next cycle. A lone `sel_fg` pulse makes the foreground bank active from the next cycle. Both together leave the state unchanged. A select never changes the contents of either bank.
- R3: A write changes only the active bank. The inactive bank keeps its values.
- R4: `rd_data` returns the selected register of the active bank. The register-select codes are: 0 control, 1 segment control, 2 address, 3 mask, 4 persistent source, 5 persistent destination.
- R5: A control write with bit 15 equal to 1 stores bits 14:0 and raises `cmp_req` for exactly the one cycle after the write edge.
- R6: A control write with bit 15 equal to 0 ignores bits 14:0 and clears both banks to the R1 defaults. It makes the foreground bank active, even if a select arrives in the same cycle. It raises `dev_rst` for the one cycle after the write edge and does not raise `cmp_req`.
- R7: Bit 15 of the control register always reads back as 0.
- R8: The active control word drives the field outputs as follows: match-flag enable from bits 14:13, full-flag enable from bits 12:11, translation from bits 10:9, partition from bits 8:6, mask select from bits 5:4, address step from bits 3:2 and mode from bits 1:0.
- R9: Registers narrower than `rd_data` keep only their low bits and read back with zeros above. The widths are: address 12 bits, segment control 8 bits, each persistent selector 4 bits.
- R10: A write in the same cycle as a select command goes to the bank that was active before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_fg | input | 1 | Select-foreground command pulse |
| sel_bg | input | 1 | Select-background command pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 16 | Active bank read data |
| active_bg | output | 1 | 1 when the background bank is active |
| cmp_req | output | 1 | Compare-request pulse |
| dev_rst | output | 1 | Device-reset pulse |
| f_mfen | output | 2 | Match-flag enable field |
| f_ffen | output | 2 | Full-flag enable field |
| f_xlat | output | 2 | Translation field |
| f_part | output | 3 | Partition field |
| f_msel | output | 2 | Mask-select field |
| f_step | output | 2 | Address-step field |
| f_mode | output | 2 | Operating-mode field |
| cur_seg | output | 8 | Active segment control |
| cur_addr | output | 12 | Active address register |
| cur_mask | output | 16 | Active mask register |
| cur_psrc | output | 4 | Active persistent source |
| cur_pdst | output | 4 | Active persistent destination |

## Verification
The bench first fills the foreground bank, switches to the background bank and reads it back. A design that shares one bank or ignores the selected bank shows foreground values there. It then writes in the same cycle as a select, where a design that applies the select first corrupts the wrong bank. It also sends a control reset together with `sel_bg`, where a design with the wrong priority ends up in the background bank. Finally it checks that reset control writes give `dev_rst` and never `cmp_req`, that bit 15 reads zero, and that every field sits at its stated bit position.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int CTRL_W = 15;

    typedef enum logic [2:0] {
        RS_CTRL = 3'd0,
        RS_SEG  = 3'd1,
        RS_ADDR = 3'd2,
        RS_MASK = 3'd3,
        RS_PSRC = 3'd4,
        RS_PDST = 3'd5
    } reg_sel_e;

    typedef enum logic {
        BANK_FG = 1'b0,
        BANK_BG = 1'b1
    } bank_st_e;

    typedef struct packed {
        logic [1:0] mfen;
        logic [1:0] ffen;
        logic [1:0] xlat;
        logic [2:0] part;
        logic [1:0] msel;
        logic [1:0] step;
        logic [1:0] mode;
    } ctrl_fields_t;
endpackage

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 8,
    parameter int ADDR_W = 12,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [2:0]        wsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [SEG_W-1:0]  seg_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [SEL_W-1:0]  psrc_q,
    output logic [SEL_W-1:0]  pdst_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            ctrl_q <= '0;
            seg_q  <= '0;
            addr_q <= '0;
            mask_q <= '0;
            psrc_q <= '0;
            pdst_q <= '0;
        end else if (we) begin
            unique case (reg_sel_e'(wsel))
                RS_CTRL: ctrl_q <= wdata[CTRL_W-1:0];
                RS_SEG:  seg_q  <= wdata[SEG_W-1:0];
                RS_ADDR: addr_q <= wdata[ADDR_W-1:0];
                RS_MASK: mask_q <= wdata;
                RS_PSRC: psrc_q <= wdata[SEL_W-1:0];
                RS_PDST: pdst_q <= wdata[SEL_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_field_dec.sv
module cfg_field_dec
    import cfgbank_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output logic [1:0]        mfen,
    output logic [1:0]        ffen,
    output logic [1:0]        xlat,
    output logic [2:0]        part,
    output logic [1:0]        msel,
    output logic [1:0]        step,
    output logic [1:0]        mode
);
    ctrl_fields_t f;

    always_comb begin
        f    = ctrl_fields_t'(ctrl);
        mfen = f.mfen;
        ffen = f.ffen;
        xlat = f.xlat;
        part = f.part;
        msel = f.msel;
        step = f.step;
        mode = f.mode;
    end
endmodule

// File: rtl/cfg_bank_file.sv
module cfg_bank_file
    import cfgbank_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 8,
    parameter int ADDR_W = 12,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fg,
    input  logic              sel_bg,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              active_bg,
    output logic              cmp_req,
    output logic              dev_rst,
    output logic [1:0]        f_mfen,
    output logic [1:0]        f_ffen,
    output logic [1:0]        f_xlat,
    output logic [2:0]        f_part,
    output logic [1:0]        f_msel,
    output logic [1:0]        f_step,
    output logic [1:0]        f_mode,
    output logic [SEG_W-1:0]  cur_seg,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_mask,
    output logic [SEL_W-1:0]  cur_psrc,
    output logic [SEL_W-1:0]  cur_pdst
);
    localparam int NBANK = 2;
    localparam int RSTB  = DATA_W - 1;

    bank_st_e state_q, state_d;
    logic ctrl_wr, rst_wr, cmd_wr;

    logic [CTRL_W-1:0] ctrl_b [NBANK];
    logic [SEG_W-1:0]  seg_b  [NBANK];
    logic [ADDR_W-1:0] addr_b [NBANK];
    logic [DATA_W-1:0] mask_b [NBANK];
    logic [SEL_W-1:0]  psrc_b [NBANK];
    logic [SEL_W-1:0]  pdst_b [NBANK];
    logic [CTRL_W-1:0] act_ctrl;

    assign ctrl_wr = wr_en && (reg_sel_e'(wr_sel) == RS_CTRL);
    assign rst_wr  = ctrl_wr && !wr_data[RSTB];
    assign cmd_wr  = ctrl_wr && wr_data[RSTB];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_FG;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (rst_wr) begin
            state_d = BANK_FG;
        end else begin
            unique case (state_q)
                BANK_FG: if (sel_bg && !sel_fg) state_d = BANK_BG;
                BANK_BG: if (sel_fg && !sel_bg) state_d = BANK_FG;
                default: state_d = BANK_FG;
            endcase
        end
    end

    // Pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_req <= 1'b0;
            dev_rst <= 1'b0;
        end else begin
            cmp_req <= cmd_wr;
            dev_rst <= rst_wr;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cfg_bank #(
            .DATA_W(DATA_W), .SEG_W(SEG_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (rst_wr),
            .we    (wr_en && !rst_wr && (state_q == bank_st_e'(b))),
            .wsel  (wr_sel),
            .wdata (wr_data),
            .ctrl_q(ctrl_b[b]),
            .seg_q (seg_b[b]),
            .addr_q(addr_b[b]),
            .mask_q(mask_b[b]),
            .psrc_q(psrc_b[b]),
            .pdst_q(pdst_b[b])
        );
    end

    // Output process
    always_comb begin
        active_bg = (state_q == BANK_BG);
        act_ctrl  = ctrl_b[active_bg];
        cur_seg   = seg_b[active_bg];
        cur_addr  = addr_b[active_bg];
        cur_mask  = mask_b[active_bg];
        cur_psrc  = psrc_b[active_bg];
        cur_pdst  = pdst_b[active_bg];
        rd_data   = '0;
        unique case (reg_sel_e'(rd_sel))
            RS_CTRL: rd_data[CTRL_W-1:0] = act_ctrl;
            RS_SEG:  rd_data[SEG_W-1:0]  = cur_seg;
            RS_ADDR: rd_data[ADDR_W-1:0] = cur_addr;
            RS_MASK: rd_data             = cur_mask;
            RS_PSRC: rd_data[SEL_W-1:0]  = cur_psrc;
            RS_PDST: rd_data[SEL_W-1:0]  = cur_pdst;
            default: rd_data             = '0;
        endcase
    end

    cfg_field_dec u_dec (
        .ctrl(act_ctrl),
        .mfen(f_mfen), .ffen(f_ffen), .xlat(f_xlat), .part(f_part),
        .msel(f_msel), .step(f_step), .mode(f_mode)
    );

    // R5
    cmp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0 && wr_data[RSTB]) |=> (cmp_req && !dev_rst));

    // R6
    reset_to_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0 && !wr_data[RSTB]) |=> (dev_rst && !cmp_req && !active_bg && rd_data == '0 || rd_sel != 3'd0 && dev_rst && !active_bg));

    // R2
    bg_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_bg && sel_bg && !sel_fg && !(wr_en && wr_sel == 3'd0 && !wr_data[RSTB])) |=> active_bg);

    // R3
    fg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_bg && !(wr_en && wr_sel == 3'd0 && !wr_data[RSTB])) |=> ($stable(ctrl_b[0]) && $stable(addr_b[0]) && $stable(mask_b[0])));

    // R7
    ctrl_bit15_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 3'd0) |-> !rd_data[RSTB]);
endmodule

// File: tb/sim_cfg_bank_file.sv
module sim_cfg_bank_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_fg = 1'b0, sel_bg = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_sel = '0, rd_sel = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        active_bg, cmp_req, dev_rst;
    logic [1:0]  f_mfen, f_ffen, f_xlat, f_msel, f_step, f_mode;
    logic [2:0]  f_part;
    logic [7:0]  cur_seg;
    logic [11:0] cur_addr;
    logic [15:0] cur_mask;
    logic [3:0]  cur_psrc, cur_pdst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cfg_bank_file u0 (
        .clk(clk), .rst_n(rst_n), .sel_fg(sel_fg), .sel_bg(sel_bg),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .active_bg(active_bg), .cmp_req(cmp_req), .dev_rst(dev_rst),
        .f_mfen(f_mfen), .f_ffen(f_ffen), .f_xlat(f_xlat), .f_part(f_part),
        .f_msel(f_msel), .f_step(f_step), .f_mode(f_mode),
        .cur_seg(cur_seg), .cur_addr(cur_addr), .cur_mask(cur_mask),
        .cur_psrc(cur_psrc), .cur_pdst(cur_pdst)
    );

    // ops: 0 write, 1 read-check, 2 select fg, 3 select bg ; {op, sel, data, exp}
    localparam int NV = 16;
    localparam logic [36:0] VEC [NV] = '{
        {2'd1, 3'd0, 16'h0000, 16'h0000},  // R1 ctrl default
        {2'd0, 3'd2, 16'h0ABC, 16'h0000},
        {2'd0, 3'd3, 16'hF0F0, 16'h0000},
        {2'd0, 3'd0, 16'h8123, 16'h0000},
        {2'd1, 3'd0, 16'h0000, 16'h0123},  // R7
        {2'd3, 3'd0, 16'h0000, 16'h0000},
        {2'd1, 3'd2, 16'h0000, 16'h0000},  // R3 bg untouched
        {2'd0, 3'd2, 16'hFFFF, 16'h0000},
        {2'd1, 3'd2, 16'h0000, 16'h0FFF},  // R9
        {2'd0, 3'd4, 16'h00A5, 16'h0000},
        {2'd1, 3'd4, 16'h0000, 16'h0005},  // R9
        {2'd2, 3'd0, 16'h0000, 16'h0000},
        {2'd1, 3'd2, 16'h0000, 16'h0ABC},  // R3 R2
        {2'd1, 3'd3, 16'h0000, 16'hF0F0},  // R4
        {2'd1, 3'd0, 16'h0000, 16'h0123},  // R4
        {2'd1, 3'd4, 16'h0000, 16'h0000}   // R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [2:0] s, input logic [15:0] exp);
        rd_sel = s;
        #1;
        chk(req, {16'd0, rd_data}, {16'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 active_bg", {31'd0, active_bg}, 32'd0);
        chk("R1 pulses", {30'd0, cmp_req, dev_rst}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 fields", {17'd0, f_mfen, f_ffen, f_xlat, f_part, f_msel, f_step, f_mode}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [2:0] s;
            logic [15:0] d, e;
            {op, s, d, e} = VEC[i];
            unique case (op)
                2'd0: do_write(s, d);
                2'd1: do_read($sformatf("R4 vec%0d", i), s, e);
                2'd2: begin sel_fg = 1'b1; tick(); sel_fg = 1'b0; end
                default: begin sel_bg = 1'b1; tick(); sel_bg = 1'b0; end
            endcase
        end
        chk("R2 back in fg", {31'd0, active_bg}, 32'd0);

        // R5 compare pulse and R8 field positions
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 16'hCEB6;
        tick();
        wr_en = 1'b0;
        chk("R5 cmp_req high", {30'd0, cmp_req, dev_rst}, 32'd2);
        chk("R8 fields", {17'd0, f_mfen, f_ffen, f_xlat, f_part, f_msel, f_step, f_mode},
            {17'd0, 2'b10, 2'b01, 2'b11, 3'b010, 2'b11, 2'b01, 2'b10});
        tick();
        chk("R5 cmp_req one cycle", {31'd0, cmp_req}, 32'd0);
        do_read("R7 bit15", 3'd0, 16'h4EB6);

        // R10 write with select same cycle: write lands in fg
        sel_bg = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 16'h005A;
        tick();
        sel_bg = 1'b0; wr_en = 1'b0;
        chk("R2 to bg", {31'd0, active_bg}, 32'd1);
        do_read("R10 bg seg", 3'd1, 16'h0000);
        do_read("R3 bg ctrl kept", 3'd0, 16'h0000);

        // R2 both selects: hold
        sel_bg = 1'b1; sel_fg = 1'b1;
        tick();
        sel_bg = 1'b0; sel_fg = 1'b0;
        chk("R2 both hold", {31'd0, active_bg}, 32'd1);
        do_read("R2 bg addr kept", 3'd2, 16'h0FFF);
        sel_fg = 1'b1; tick(); sel_fg = 1'b0;
        do_read("R10 fg seg", 3'd1, 16'h005A);
        sel_bg = 1'b1; tick(); sel_bg = 1'b0;
        do_write(3'd0, 16'h8003);

        // R6 reset write in bg with concurrent sel_bg
        sel_bg = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 16'h7FFF;
        tick();
        sel_bg = 1'b0; wr_en = 1'b0;
        chk("R6 pulses", {30'd0, cmp_req, dev_rst}, 32'd1);
        chk("R6 fg active", {31'd0, active_bg}, 32'd0);
        do_read("R6 fg ctrl cleared", 3'd0, 16'h0000);
        do_read("R6 fg addr cleared", 3'd2, 16'h0000);
        do_read("R6 fg seg cleared", 3'd1, 16'h0000);
        tick();
        chk("R6 dev_rst one cycle", {31'd0, dev_rst}, 32'd0);
        sel_bg = 1'b1; tick(); sel_bg = 1'b0;
        do_read("R6 bg ctrl cleared", 3'd0, 16'h0000);
        do_read("R6 bg addr cleared", 3'd2, 16'h0000);
        do_read("R6 bg psrc cleared", 3'd4, 16'h0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule